// File: doc/BRIEF.md
# Platform interrupt controller

This block gathers level-sensitive interrupt requests from a set of peripheral sources and steers them to a number of hart contexts. Every source has a small priority value. Every context has its own enable bitmap, its own priority threshold and its own claim/complete register. A context's interrupt line rises when at least one source is pending, enabled for that context and ranked strictly above that context's threshold.

Software takes an interrupt by reading the claim register of its context. The read returns the identifier of the best eligible source and removes that source from the pending set in the same cycle. Software then writes the identifier back to the same register to signal completion. Between claim and completion, the source's gateway ignores its request line. Source identifier 0 is reserved and means "nothing".

Software reaches all registers over a simple synchronous bus with word addresses. Each read returns its data in the cycle after the request.

Top module: `irq_hub`

## Requirements
- R1: After reset every priority, enable bit and threshold is 0. Every interrupt output is low, and a claim read returns 0.
- R2: The priority of source n (3 bits, in data bits 2:0) is at word address n. Source 0's priority always reads 0, and writes to it are dropped. Upper data bits of a priority write are discarded.
- R3: The enable bitmap of context c starts at word 0x800 + 32·c. Source n is bit (n mod 32) of word n/32 within it. Bit 0 of word 0 always reads 0.
- R4: Context c has its threshold (3 bits) at word 0x80000 + 1024·c and its claim/complete register at the next word.
- R5: The interrupt output of a context is high exactly when some pending source enabled for that context has priority strictly above the context's threshold. Priority 0 never interrupts, and threshold 7 masks everything.
- R6: A claim read returns the eligible source with the highest priority. A tie goes to the lowest identifier. The read returns 0 when no source is eligible. Read data appears the cycle after the request.
- R7: A claim read clears the returned source's pending state in that cycle, so back-to-back claim reads return distinct sources and then 0.
- R8: A claimed source accepts no new request until it is completed, even with its level held high. After completion, a high level makes it pending again on the next clock edge.
- R9: A completion write naming a source that is not enabled in the writing context is ignored.
- R10: Reads of unmapped words return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | NSRC | Level request per source; bit 0 is unused |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | NCTX | Interrupt request per context |

## Verification
The bench targets the selection corner cases. Two sources tie on priority, and a design that picked the higher identifier would return them in the wrong order. A later source outranks a lower identifier, which catches a selector that scans for the first eligible source only. Level inputs stay high across claims. A leaky gateway would then hand the same source out twice before completion. A completion is written from a context where the source is disabled, and a design that accepted it would re-arm the source early. Thresholds of 7 and 4 check that the comparison is strict and masks correctly. Reserved and unmapped words are written and read back, which catches decoding that aliases or accepts stray writes.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  typedef enum logic [1:0] {
    GW_OPEN = 2'd0,
    GW_PEND = 2'd1,
    GW_HELD = 2'd2
  } gw_state_e;

  localparam int ENA_BASE_W    = 32'h800;
  localparam int ENA_STRIDE_LG = 5;
  localparam int CTX_BASE_W    = 32'h80000;
  localparam int CTX_STRIDE_LG = 10;
  localparam int REG_THR       = 0;
  localparam int REG_CLAIM     = 1;
endpackage

// File: rtl/irq_hub_gateway.sv
module irq_hub_gateway
  import irq_hub_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic take,
  input  logic finish,
  output logic pending,
  output logic held
);
  gw_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= GW_OPEN;
    end else begin
      case (st)
        GW_OPEN: if (level)  st <= GW_PEND;
        GW_PEND: if (take)   st <= GW_HELD;
        GW_HELD: if (finish) st <= GW_OPEN;
        default:             st <= GW_OPEN;
      endcase
    end
  end

  assign pending = (st == GW_PEND);
  assign held    = (st == GW_HELD);

  AST_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !finish) |=> !pending) else $error("gateway reopened early"); // R8
  AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && take) |=> (!pending && held)) else $error("claim did not clear"); // R7
endmodule

// File: rtl/irq_hub_select.sv
module irq_hub_select #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC-1:0]        ena,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]      thr,
  output logic [ID_W-1:0]        best_id,
  output logic                   any
);
  function automatic logic eligible(input logic p, input logic e,
                                    input logic [PRIO_W-1:0] pr,
                                    input logic [PRIO_W-1:0] th);
    return p && e && (pr > th);
  endfunction

  function automatic logic outranks(input logic [PRIO_W-1:0] cand,
                                    input logic [PRIO_W-1:0] best);
    return cand > best;
  endfunction

  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_id = '0;
    best_p  = '0;
    any     = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (eligible(pend[i], ena[i], prio_flat[i*PRIO_W +: PRIO_W], thr) &&
          (!any || outranks(prio_flat[i*PRIO_W +: PRIO_W], best_p))) begin
        any     = 1'b1;
        best_p  = prio_flat[i*PRIO_W +: PRIO_W];
        best_id = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_level,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [NCTX-1:0]   irq_out
);
  localparam int ID_W      = $clog2(NSRC);
  localparam int CTX_W     = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam int ENA_WORDS = (NSRC + 31) / 32;
  localparam int ENA_BITS  = ENA_WORDS * 32;

  function automatic logic [ENA_BITS-1:0] ena_mask();
    logic [ENA_BITS-1:0] m;
    m = '0;
    for (int i = 1; i < NSRC; i++) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [ENA_BITS-1:0] ENA_MASK = ena_mask();

  // storage
  logic [PRIO_W-1:0]   prio_q [NSRC];
  logic [ENA_BITS-1:0] ena_q  [NCTX];
  logic [PRIO_W-1:0]   thr_q  [NCTX];

  // decode
  logic [ADDR_W-1:0]        ena_off, ctx_off;
  logic                     prio_hit, ena_hit, ctx_hit;
  logic [ID_W-1:0]          prio_idx;
  logic [CTX_W-1:0]         ena_ctx, ctx_sel;
  logic [ENA_STRIDE_LG-1:0] ena_word;
  logic [CTX_STRIDE_LG-1:0] ctx_reg;
  logic                     is_thr, is_clm;

  assign ena_off  = bus_addr - ADDR_W'(ENA_BASE_W);
  assign ctx_off  = bus_addr - ADDR_W'(CTX_BASE_W);
  assign prio_hit = bus_valid && (bus_addr < ADDR_W'(NSRC));
  assign prio_idx = bus_addr[ID_W-1:0];
  assign ena_word = ena_off[ENA_STRIDE_LG-1:0];
  assign ena_ctx  = CTX_W'(ena_off >> ENA_STRIDE_LG);
  assign ena_hit  = bus_valid && (bus_addr >= ADDR_W'(ENA_BASE_W)) &&
                    ((ena_off >> ENA_STRIDE_LG) < ADDR_W'(NCTX)) &&
                    (ADDR_W'(ena_word) < ADDR_W'(ENA_WORDS));
  assign ctx_reg  = ctx_off[CTX_STRIDE_LG-1:0];
  assign ctx_sel  = CTX_W'(ctx_off >> CTX_STRIDE_LG);
  assign is_thr   = (ctx_reg == CTX_STRIDE_LG'(REG_THR));
  assign is_clm   = (ctx_reg == CTX_STRIDE_LG'(REG_CLAIM));
  assign ctx_hit  = bus_valid && (bus_addr >= ADDR_W'(CTX_BASE_W)) &&
                    ((ctx_off >> CTX_STRIDE_LG) < ADDR_W'(NCTX)) &&
                    (is_thr || is_clm);

  // gateways
  logic [NSRC-1:0] pend_vec, busy_vec;
  logic [ID_W-1:0] win_id  [NCTX];
  logic [NCTX-1:0] win_any;
  logic [ID_W-1:0] claim_id;
  logic            claim_rd, cmp_wr, cmp_ok;
  logic [ENA_BITS-1:0] ena_sel;
  logic            unused_id0;

  assign unused_id0 = src_level[0];
  assign claim_rd   = ctx_hit && !bus_write && is_clm;
  assign cmp_wr     = ctx_hit && bus_write && is_clm;
  assign claim_id   = win_id[ctx_sel];
  assign ena_sel    = ena_q[ctx_sel];
  assign cmp_ok     = cmp_wr && (bus_wdata < 32'(NSRC)) && (bus_wdata != 32'd0) &&
                      ena_sel[bus_wdata[ID_W-1:0]];

  assign pend_vec[0] = 1'b0;
  assign busy_vec[0] = 1'b0;

  for (genvar i = 1; i < NSRC; i++) begin : g_gw
    irq_hub_gateway u_gw (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (src_level[i]),
      .take    (claim_rd && (claim_id == ID_W'(i))),
      .finish  (cmp_ok && (bus_wdata[ID_W-1:0] == ID_W'(i))),
      .pending (pend_vec[i]),
      .held    (busy_vec[i])
    );
  end

  // selection per context
  logic [NSRC*PRIO_W-1:0] prio_flat;
  always_comb begin
    for (int i = 0; i < NSRC; i++) prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    irq_hub_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
      .pend      (pend_vec),
      .ena       (ena_q[c][NSRC-1:0]),
      .prio_flat (prio_flat),
      .thr       (thr_q[c]),
      .best_id   (win_id[c]),
      .any       (win_any[c])
    );
    assign irq_out[c] = win_any[c];
  end

  // register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        ena_q[c] <= '0;
        thr_q[c] <= '0;
      end
    end else if (bus_write) begin
      if (prio_hit) begin
        for (int i = 1; i < NSRC; i++)
          if (prio_idx == ID_W'(i)) prio_q[i] <= bus_wdata[PRIO_W-1:0];
      end
      if (ena_hit) begin
        for (int c = 0; c < NCTX; c++)
          for (int w = 0; w < ENA_WORDS; w++)
            if (ena_ctx == CTX_W'(c) && ena_word == ENA_STRIDE_LG'(w))
              ena_q[c][w*32 +: 32] <= bus_wdata & ENA_MASK[w*32 +: 32];
      end
      if (ctx_hit && is_thr) begin
        for (int c = 0; c < NCTX; c++)
          if (ctx_sel == CTX_W'(c)) thr_q[c] <= bus_wdata[PRIO_W-1:0];
      end
    end
  end

  // read path
  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (prio_hit) begin
      rd_val = 32'(prio_q[prio_idx]);
    end else if (ena_hit) begin
      for (int c = 0; c < NCTX; c++)
        for (int w = 0; w < ENA_WORDS; w++)
          if (ena_ctx == CTX_W'(c) && ena_word == ENA_STRIDE_LG'(w))
            rd_val = ena_q[c][w*32 +: 32];
    end else if (ctx_hit) begin
      rd_val = is_thr ? 32'(thr_q[ctx_sel]) : 32'(claim_id);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_valid && !bus_write;
      rsp_rdata <= (bus_valid && !bus_write) ? rd_val : '0;
    end
  end

  AST_CLAIM_OVER_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rd && claim_id != '0) |-> (prio_q[claim_id] > thr_q[ctx_sel]))
    else $error("claimed source not above threshold"); // R5
  AST_BAD_FINISH_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !cmp_ok) |=> $stable(busy_vec))
    else $error("ignored completion changed a gateway"); // R9
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid)
    else $error("read not answered next cycle"); // R6
  AST_NO_IRQ_IN_RESET: assert property (@(posedge clk)
    $past(!rst_n) |-> (irq_out == '0))
    else $error("irq high out of reset"); // R1
endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  localparam int NSRC = 32;
  localparam int NCTX = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NSRC-1:0]   src_level = '0;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [19:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [NCTX-1:0]   irq_out;

  always #10 clk = ~clk;

  irq_hub #(.NSRC(NSRC), .NCTX(NCTX)) u0 (
    .clk(clk), .rst_n(rst_n), .src_level(src_level),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_out(irq_out)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t exq[$];

  function automatic logic [19:0] a_prio(int n); return 20'(n); endfunction
  function automatic logic [19:0] a_ena(int c, int w); return 20'(32'h800 + c*32 + w); endfunction
  function automatic logic [19:0] a_thr(int c); return 20'(32'h80000 + c*1024); endfunction
  function automatic logic [19:0] a_clm(int c); return 20'(32'h80000 + c*1024 + 1); endfunction

  // driver tasks: called at a falling edge, return at the next falling edge
  task automatic bus_wr(input logic [19:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [19:0] a, input logic [31:0] e, input string tag);
    exp_t x;
    x.v = e; x.tag = tag;
    exq.push_back(x);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic check_irq(input logic [NCTX-1:0] e, input string tag);
    n_run++;
    if (irq_out !== e) begin
      n_fail++;
      $display("FAIL %s irq_out actual=%b expected=%b", tag, irq_out, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard pop on each read response
  always @(negedge clk) begin
    if (rsp_valid) begin
      n_run++;
      if (exq.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        exp_t x;
        x = exq.pop_front();
        if (rsp_rdata !== x.v) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", x.tag, rsp_rdata, x.v);
        end
      end
    end
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check_irq(2'b00, "R1 irq after reset");
    bus_rd(a_prio(3), 32'd0, "R1 priority after reset");
    bus_rd(a_ena(0, 0), 32'd0, "R1 enable after reset");
    bus_rd(a_thr(0), 32'd0, "R1 threshold after reset");
    bus_rd(a_clm(0), 32'd0, "R1 claim after reset");

    // R2 priority map
    bus_wr(a_prio(0), 32'd7);
    bus_rd(a_prio(0), 32'd0, "R2 source 0 priority");
    bus_wr(a_prio(12), 32'hFF);
    bus_rd(a_prio(12), 32'd7, "R2 priority width");
    bus_wr(a_prio(3), 32'd5);
    bus_wr(a_prio(5), 32'd5);
    bus_wr(a_prio(7), 32'd2);
    bus_rd(a_prio(3), 32'd5, "R2 priority readback");

    // R3 enable map
    bus_wr(a_ena(0, 0), 32'hFFFF_FFFF);
    bus_rd(a_ena(0, 0), 32'hFFFF_FFFE, "R3 enable bit 0 reads 0");
    bus_wr(a_ena(1, 0), 32'h0000_0080);
    bus_rd(a_ena(1, 0), 32'h0000_0080, "R3 context 1 enable");

    // R4 threshold
    bus_wr(a_thr(0), 32'd1);
    bus_rd(a_thr(0), 32'd1, "R4 threshold readback");

    // raise levels
    src_level[3] = 1'b1; src_level[5] = 1'b1; src_level[7] = 1'b1; src_level[9] = 1'b1;
    idle(2);
    check_irq(2'b11, "R5 both contexts interrupt");
    bus_rd(a_clm(0), 32'd3, "R6 tie goes to lowest id");
    bus_rd(a_clm(0), 32'd5, "R7 second claim distinct");
    bus_rd(a_clm(0), 32'd7, "R7 third claim");
    bus_rd(a_clm(0), 32'd0, "R5 priority 0 not claimable");
    check_irq(2'b00, "R5 nothing eligible after claims");

    // R8 gateway stays shut with level high
    idle(3);
    bus_rd(a_clm(0), 32'd0, "R8 no re-pend before completion");

    // R9 completion from a context where the source is disabled
    bus_wr(a_clm(1), 32'd3);
    idle(3);
    bus_rd(a_clm(0), 32'd0, "R9 ignored completion");
    check_irq(2'b00, "R9 irq still low");

    // R8 real completion re-arms
    bus_wr(a_clm(0), 32'd3);
    idle(3);
    check_irq(2'b01, "R8 re-pend after completion");
    bus_rd(a_clm(0), 32'd3, "R8 claim after completion");

    // R5 threshold masking
    bus_wr(a_clm(0), 32'd5);
    idle(3);
    bus_wr(a_thr(0), 32'd7);
    check_irq(2'b00, "R5 threshold 7 masks");
    bus_rd(a_clm(0), 32'd0, "R5 threshold 7 claim");
    bus_wr(a_thr(0), 32'd4);
    check_irq(2'b01, "R5 priority 5 above threshold 4");
    bus_rd(a_clm(0), 32'd5, "R6 claim above threshold");

    // R6 higher priority beats lower id
    bus_wr(a_prio(9), 32'd6);
    bus_wr(a_clm(0), 32'd3);
    idle(3);
    bus_rd(a_clm(0), 32'd9, "R6 priority beats id");
    bus_rd(a_clm(0), 32'd3, "R6 next best");
    bus_rd(a_clm(0), 32'd0, "R7 drained to 0");

    // context 1 completion of its own source
    bus_wr(a_clm(1), 32'd7);
    idle(3);
    check_irq(2'b10, "R8 context 1 re-armed");
    bus_rd(a_clm(1), 32'd7, "R7 context 1 claim");

    // R4 context 1 threshold word
    bus_wr(a_thr(1), 32'hA);
    bus_rd(a_thr(1), 32'd2, "R4 context 1 threshold");

    // R10 unmapped
    bus_wr(20'h400, 32'hFFFF);
    bus_rd(20'h400, 32'd0, "R10 unmapped read");
    bus_rd(20'(32'h80000 + 2), 32'd0, "R10 context gap word");
    bus_wr(a_ena(0, 1), 32'hFFFF_FFFF);
    bus_rd(a_ena(0, 1), 32'd0, "R10 enable word beyond sources");
    bus_rd(a_ena(2, 0), 32'd0, "R10 missing context");
    bus_rd(a_ena(0, 0), 32'hFFFF_FFFE, "R10 neighbours untouched");

    idle(3);
    n_run++;
    if (exq.size() != 0) begin
      n_fail++;
      $display("FAIL R6 missing responses actual=%0d expected=0", exq.size());
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule